// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Unit

This unit is an arithmetic datapath slice for a signal-processing core. Each operand word holds two signed 16-bit halfwords. The unit forms both lane products, low by low and high by high. Before multiplying it can swap the two halves of the second operand. It then adds the two products or subtracts the high one from the low one. On request it folds in an accumulator, which is 32 bits wide for the short forms and 64 bits wide for the long forms.

A separate high-word mode multiplies the two full 32-bit words as signed values. It keeps bits 63:32 of the product, drops the lower word, and can add a 32-bit accumulator to the kept word.

The datapath is a two-stage registered pipeline and accepts a new operation every cycle. A sticky flag records any signed overflow of a 32-bit dual sum. The result itself always wraps.

Top module: `dmac_unit`

## Requirements
- R1: An operation presented with `valid_i` high at rising edge N appears on `result_o` with `valid_o` high after rising edge N+2. Operations may be issued back to back.
- R2: Bit encoding of `op_i`:
  - bit 0 swaps the halves of operand B.
  - bit 1 selects difference instead of sum.
  - bit 2 selects the 64-bit form.
  - bit 3 adds the accumulator.
  - bit 4 selects high-word mode.

  With all bits clear except bit 3, the result is A.lo*B.lo + A.hi*B.hi + acc[31:0]. For example, 0x00030002 and 0x00050004 with accumulator 0x20000000 give 0x20000017.
- R3: With bit 0 set, B.lo and B.hi are exchanged before both products are formed. For example, 0x00030002 and 0x00050004 with accumulator 0x800 give 0x816.
- R4: With bit 1 set, the combination is A.lo*B'.lo - A.hi*B'.hi. For example, 0x00030006 and 0x00050004 with accumulator 0x800 give 0x809.
- R5: With bit 2 set, the signed 64-bit value of the combination is added to the 64-bit accumulator, modulo 2^64. These forms never set the overflow flag.
- R6: With bit 3 clear, the accumulator is ignored, and halfwords are still treated as signed. For example, 0xFFFDFFFF and 0x00040002 give 0xFFFFFFF2 as a sum and 0x0000000A as a difference.
- R7: With bit 4 set, the result is bits 63:32 of the signed 32x32 product, plus acc[31:0] when bit 3 is set. Bits 0 to 2 are ignored in this mode. For example, 0x40000000 and 0x10 with accumulator 0x300 give 0x304.
- R8: Overflow flag behaviour:
  - It is set when a 32-bit dual sum (bits 1, 2 and 4 clear), including the accumulator, falls outside the signed 32-bit range.
  - It rises together with the `valid_o` of that operation.
  - It stays high until reset.
  - Difference forms and high-word forms never set it.
  - The result wraps in every case.
- R9: While `rst_ni` is low, `valid_o`, `result_o` and `ovf_o` are all zero.
- R10: In every 32-bit form (high-word mode, or bit 2 clear), `result_o[63:32]` is zero.
- R11: While `valid_o` is low, `result_o` keeps the last delivered value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on the inputs |
| op_a_i | input | 32 | Operand A, two signed halfwords or one signed word |
| op_b_i | input | 32 | Operand B, two signed halfwords or one signed word |
| acc_i | input | 64 | Accumulator; the short forms use bits 31:0 |
| op_i | input | 5 | Operation selectors, encoded as in R2 |
| valid_o | output | 1 | Result delivered |
| result_o | output | 64 | Result; upper word is zero for the short forms |
| ovf_o | output | 1 | Sticky overflow of the 32-bit dual sum |

## Verification
A stale or misrouted stage-1 register, such as a lane product or a latched selector, shows up as a wrong `result_o` exactly two cycles after the operation that fed it. No later cycle can hide it, because every delivered result is compared. A wrong sign extension or a swapped lane gives differences that only signed or asymmetric halfwords expose, so the directed vectors use negative halves and unequal lanes. A missed or spurious overflow latch is visible on `ovf_o` in the same cycle as the offending result, and it persists from then on. For that reason the overflow-free directed vectors run before the first overflowing one.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int OP_W = 5;

  typedef struct packed {
    logic hiword;   // bit 4
    logic accum;    // bit 3
    logic long_m;   // bit 2
    logic sub;      // bit 1
    logic xchg;     // bit 0
  } dmac_op_t;
endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter int HW = 16
) (
  input  logic [HW-1:0]   a_i,
  input  logic [HW-1:0]   b_i,
  output logic [2*HW-1:0] p_o
);
  logic signed [2*HW-1:0] a_x, b_x;
  assign a_x = {{HW{a_i[HW-1]}}, a_i};
  assign b_x = {{HW{b_i[HW-1]}}, b_i};
  assign p_o = a_x * b_x;
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine
  import dmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   p_lo_i,
  input  logic [DW-1:0]   p_hi_i,
  input  logic [DW-1:0]   mhi_i,
  input  logic [2*DW-1:0] acc_i,
  input  dmac_op_t        op_i,
  output logic [2*DW-1:0] res_o,
  output logic            ovf_o
);
  localparam int W2 = 2 * DW;

  logic [W2-1:0] lo_x, hi_x, d, acc_eff, acc_n, wide;
  logic [DW:0]   top_bits;

  assign lo_x     = {{DW{p_lo_i[DW-1]}}, p_lo_i};
  assign hi_x     = {{DW{p_hi_i[DW-1]}}, p_hi_i};
  assign d        = op_i.sub ? (lo_x - hi_x) : (lo_x + hi_x);
  assign acc_eff  = op_i.accum ? acc_i : '0;
  assign acc_n    = {{DW{acc_eff[DW-1]}}, acc_eff[DW-1:0]};
  assign wide     = d + acc_n;
  assign top_bits = wide[W2-1:DW-1];

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    if (op_i.hiword) begin
      res_o[DW-1:0] = mhi_i + acc_eff[DW-1:0];
    end else if (op_i.long_m) begin
      res_o = d + acc_eff;
    end else begin
      res_o[DW-1:0] = wide[DW-1:0];
      // exact sum out of signed 32-bit range
      ovf_o = !op_i.sub && !((&top_bits) || !(|top_bits));
    end
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [DW-1:0]       op_a_i,
  input  logic [DW-1:0]       op_b_i,
  input  logic [2*DW-1:0]     acc_i,
  input  logic [OP_W-1:0]     op_i,
  output logic                valid_o,
  output logic [2*DW-1:0]     result_o,
  output logic                ovf_o
);
  localparam int HW    = DW / 2;
  localparam int LANES = 2;
  localparam int W2    = 2 * DW;

  dmac_op_t op_in;
  logic [DW-1:0] b_sel;
  logic [LANES-1:0][DW-1:0] lane_p;
  logic [W2-1:0] a_ext, b_ext, full_p;

  assign op_in = dmac_op_t'(op_i);
  assign b_sel = op_in.xchg ? {op_b_i[HW-1:0], op_b_i[DW-1:HW]} : op_b_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmac_lane_mul #(.HW(HW)) u_mul (
      .a_i (op_a_i[g*HW +: HW]),
      .b_i (b_sel[g*HW +: HW]),
      .p_o (lane_p[g])
    );
  end

  assign a_ext  = {{DW{op_a_i[DW-1]}}, op_a_i};
  assign b_ext  = {{DW{op_b_i[DW-1]}}, op_b_i};
  assign full_p = a_ext * b_ext;

  // stage 1: products and selectors
  logic                     v1_q;
  logic [LANES-1:0][DW-1:0] lane_q;
  logic [DW-1:0]            mhi_q;
  logic [W2-1:0]            acc_q;
  dmac_op_t                 op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      lane_q <= '0;
      mhi_q  <= '0;
      acc_q  <= '0;
      op_q   <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        lane_q <= lane_p;
        mhi_q  <= full_p[W2-1:DW];
        acc_q  <= acc_i;
        op_q   <= op_in;
      end
    end
  end

  // stage 2: combine and accumulate
  logic [W2-1:0] comb_res;
  logic          comb_ovf;

  dmac_combine #(.DW(DW)) u_comb (
    .p_lo_i (lane_q[0]),
    .p_hi_i (lane_q[1]),
    .mhi_i  (mhi_q),
    .acc_i  (acc_q),
    .op_i   (op_q),
    .res_o  (comb_res),
    .ovf_o  (comb_ovf)
  );

  logic          valid_q, ovf_q;
  logic [W2-1:0] res_q;
  dmac_op_t      out_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      res_q    <= '0;
      ovf_q    <= 1'b0;
      out_op_q <= '0;
    end else begin
      valid_q <= v1_q;
      ovf_q   <= ovf_q | (v1_q & comb_ovf);
      if (v1_q) begin
        res_q    <= comb_res;
        out_op_q <= op_q;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;

  assert_sticky_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  assert_ovf_with_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> valid_o);

  assert_ovf_only_short_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (!out_op_q.sub && !out_op_q.long_m && !out_op_q.hiword));

  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (out_op_q.hiword || !out_op_q.long_m)) |-> (result_o[W2-1:DW] == '0));

  assert_hold_result_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

// File: tb/dmac_unit_test.sv
`timescale 1ns/1ps
module dmac_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [31:0] op_a_i, op_b_i;
  logic [63:0] acc_i;
  logic [4:0]  op_i;
  logic        valid_o;
  logic [63:0] result_o;
  logic        ovf_o;

  always #2 clk = ~clk;

  dmac_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .acc_i(acc_i), .op_i(op_i), .valid_o(valid_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, sticky_exp = 0;
  logic [63:0] last_res = '0;
  logic        rv[4];
  logic        rovf[4];
  logic [63:0] rres[4];
  string       rtag[4];

  function automatic logic [64:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] acc, input logic [4:0] op);
    longint ax, bx2, prod, p0, p1, d, s, acc32;
    logic [31:0] bs;
    logic [63:0] pw, r64;
    if (op[4]) begin
      ax = $signed(a); bx2 = $signed(b);
      prod = ax * bx2;
      pw = prod;
      return {1'b0, 32'h0, pw[63:32] + (op[3] ? acc[31:0] : 32'h0)};
    end
    bs = op[0] ? {b[15:0], b[31:16]} : b;
    p0 = $signed(a[15:0]);  p0 = p0 * longint'($signed(bs[15:0]));
    p1 = $signed(a[31:16]); p1 = p1 * longint'($signed(bs[31:16]));
    d  = op[1] ? p0 - p1 : p0 + p1;
    if (op[2]) begin
      r64 = d + (op[3] ? acc : 64'h0);
      return {1'b0, r64};
    end
    acc32 = $signed(acc[31:0]);
    s = d + (op[3] ? acc32 : 64'sd0);
    r64 = s;
    return {(!op[1] && (s > 64'sd2147483647 || s < -64'sd2147483648)), 32'h0, r64[31:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_slot(input int k);
    int s = k % 4;
    sticky_exp = sticky_exp | rovf[s];
    check(valid_o === rv[s], "R1 valid", {63'h0, valid_o}, {63'h0, rv[s]});
    if (rv[s]) begin
      check(result_o === rres[s], rtag[s], result_o, rres[s]);
      last_res = rres[s];
    end else begin
      check(result_o === last_res, "R11 hold", result_o, last_res);
    end
    check(ovf_o === sticky_exp, "R8 ovf", {63'h0, ovf_o}, {63'h0, sticky_exp});
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input logic [63:0] acc, input logic [4:0] op, input string tag);
    logic [64:0] m;
    int s;
    @(negedge clk);
    if (cyc >= 2) check_slot(cyc - 2);
    m = model(a, b, acc, op);
    s = cyc % 4;
    rv[s] = v; rres[s] = m[63:0]; rovf[s] = v & m[64]; rtag[s] = tag;
    valid_i = v; op_a_i = a; op_b_i = b; acc_i = acc; op_i = op;
    cyc++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 0; valid_i = 0; op_a_i = 0; op_b_i = 0; acc_i = 0; op_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid_o === 1'b0 && result_o === 64'h0 && ovf_o === 1'b0, "R9 reset",
          {valid_o, ovf_o, result_o[61:0]}, 64'h0);
    rst_ni = 1;

    step(1, 32'h00030002, 32'h00050004, 64'h20000000, 5'h08, "R2 dual sum acc");
    step(1, 32'h00030002, 32'h00050004, 64'h800, 5'h09, "R3 exchange sum");
    step(1, 32'h00030006, 32'h00050004, 64'h800, 5'h0A, "R4 difference");
    step(1, 32'h00030002, 32'h00050004, 64'h800, 5'h0B, "R4 R3 exchanged difference");
    step(0, 32'h0, 32'h0, 64'h0, 5'h00, "R11 gap");
    step(0, 32'hDEADBEEF, 32'h1234, 64'h1, 5'h1F, "R11 gap");
    step(1, 32'h00030002, 32'h00050004, 64'h0000000200000000, 5'h0C, "R5 long sum");
    step(1, 32'h00000001, 32'h00000001, 64'hFFFFFFFFFFFFFFFF, 5'h0C, "R5 long wrap");
    step(1, 32'hFFFDFFFF, 32'h00040002, 64'hFFFF, 5'h00, "R6 signed sum no acc");
    step(1, 32'hFFFDFFFF, 32'h00040002, 64'hFFFF, 5'h02, "R6 signed diff no acc");
    step(1, 32'h00030001, 32'h00040002, 64'h0, 5'h03, "R6 R3 exchanged diff");
    step(1, 32'h40000000, 32'h00000010, 64'h300, 5'h18, "R7 high word acc");
    step(1, 32'h00000200, 32'h00000004, 64'h100, 5'h18, "R7 high word truncation");
    step(1, 32'hFFFFFFFF, 32'h00000002, 64'h12345, 5'h17, "R7 negative, selectors ignored");
    step(1, 32'h00000001, 32'h00000001, 64'h7FFFFFFF, 5'h0A, "R8 diff wraps no flag R10");
    step(1, 32'h00000001, 32'h00000001, 64'h7FFFFFFF, 5'h0E, "R5 long no flag");
    step(1, 32'h7FFF0000, 32'h7FFF0000, 64'hFFFFFFFF80000000, 5'h0C, "R5 long negative acc");
    step(1, 32'h80008000, 32'h80008000, 64'h0, 5'h00, "R8 sum overflow wraps");
    step(1, 32'h00010001, 32'h00010001, 64'h0, 5'h00, "R8 sticky");

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom, $urandom, {$urandom, $urandom},
           5'($urandom), "R2 R10 random");
    end
    step(0, 0, 0, 0, 0, "R1 flush");
    step(0, 0, 0, 0, 0, "R1 flush");
    step(0, 0, 0, 0, 0, "R1 flush");

    done = 1;
    summary();
    $finish;
  end
endmodule